// File: doc/BRIEF.md
# Bit-Enable Write Control Register Bank

This block is an APB slave holding the configuration and status words of a serial display transmitter PHY. It has eleven 16-bit control words and two status words, each at a 32-bit word-aligned offset. Software can change one field of a control word without first reading it back. On every write, the upper half of the bus word acts as a per-bit enable for the lower half. Only the lower-half bits whose enable is set take the new value. Every other bit keeps what it held.

The stored control bits go straight to the PHY as named field outputs: lane idle and power-down, the PLL dividers and controls, line rate, termination, per-lane emphasis, amplitude and amplitude scale, spread-spectrum settings, and the side-channel power and idle bits. Two status words are captured from PHY inputs on every clock: the PLL lock indication and a 16-bit general status word. The slave never inserts wait states. An access to any offset outside the decoded set is answered with a slave error.

Top module: `wmask_csr_bank`

## Requirements
- R1: After reset, the word at 0x00 reads 0x00000FF1, which means every lane is idle and powered down and the PLL is powered down. Every other control word reads zero.
- R2: A write to a control word replaces data bit n (n = 0..15) with pwdata[n] only when pwdata[n+16] is 1. A bit whose enable is 0 keeps its previous value.
- R3: A write takes effect only at the rising edge that ends an access phase (psel, penable and pwrite all high), and the outputs show the new value from the following cycle. A setup phase alone (psel high, penable low) changes nothing.
- R4: The control words sit at offsets 0x00, 0x04, ... 0x28, and each is an independent storage word. A read in the access phase returns the 16 stored bits in prdata[15:0] with prdata[31:16] at zero.
- R5: The word at 0x00 drives lane idle from bits [11:8], lane power-down from [7:4], the quiescent-current test enable from bit 1 and PLL power-down from bit 0. Lane k uses bit k of each lane field.
- R6: The word at 0x04 drives the 15-bit PLL feedback divider from bits [14:0]. The word at 0x08 drives termination from [10:8], rate select from [5:4] and reference divider from [3:0].
- R7: The word at 0x18 drives spread depth from [15:12], spread enable from bit 11 and spread count from [9:0]. The word at 0x0C gives lane k emphasis in bits [4k+3:4k]. The word at 0x10 gives lane k a 3-bit amplitude in bits [4k+2:4k]. The word at 0x14 gives lane k amplitude scale in [2k+1:2k] and the transmit mode in [9:8]. The words at 0x1C, 0x20 and 0x24 drive 16-bit spare, PLL-high and transmit-control outputs. The word at 0x28 drives the side-channel receiver power-down select (bit 5), driver power-down select (bit 4), idle (bit 2), receiver power-down (bit 1) and driver power-down (bit 0).
- R8: A read of 0x30 returns pll_ready as sampled at the previous rising edge in bit 0, with all other bits zero. A read of 0x34 returns phy_status as sampled at the previous rising edge.
- R9: Writes to 0x30 and 0x34 are accepted without error and change no stored bit.
- R10: An access to any other offset returns pslverr = 1 and prdata = 0 in its access phase, and a write there changes nothing. This covers 0x2C, offsets from 0x38 up, and any offset with paddr[1:0] not 00.
- R11: pready is always 1. Outside a read access phase prdata is zero, and outside an access phase pslverr is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus clock |
| presetn | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W (8) | Byte offset |
| pwdata | input | 32 | [31:16] bit enables, [15:0] data |
| prdata | output | 32 | Read data |
| pready | output | 1 | Always 1 |
| pslverr | output | 1 | Undecoded offset in access phase |
| pll_ready | input | 1 | PLL lock indication |
| phy_status | input | 16 | General PHY status word |
| lane_idle | output | LANES (4) | Per-lane idle |
| lane_pd | output | LANES (4) | Per-lane power-down |
| iddq_en | output | 1 | Quiescent-current test enable |
| pll_pd | output | 1 | PLL power-down |
| pll_fbdiv | output | 15 | PLL feedback divider |
| term_sel | output | 3 | Termination select |
| rate_sel | output | 2 | Line rate select |
| ref_div | output | 4 | Reference divider |
| emph | output | 4*LANES | Per-lane emphasis |
| amp | output | 3*LANES | Per-lane amplitude |
| amp_scale | output | 2*LANES | Per-lane amplitude scale |
| tx_mode | output | 2 | Transmit mode |
| ssc_depth | output | 4 | Spread depth |
| ssc_en | output | 1 | Spread enable |
| ssc_count | output | 10 | Spread count |
| spare_ctl | output | 16 | Spare control word |
| pll_ctl_hi | output | 16 | PLL high control word |
| tx_ctl | output | 16 | Transmit control word |
| aux_rx_pd_sel | output | 1 | Side-channel receiver power-down select |
| aux_tx_pd_sel | output | 1 | Side-channel driver power-down select |
| aux_idle | output | 1 | Side-channel idle |
| aux_rx_pd | output | 1 | Side-channel receiver power-down |
| aux_tx_pd | output | 1 | Side-channel driver power-down |

## Verification
The bench attacks the enable mask with partial masks and all-zero masks. A design that wrote the whole lower half would corrupt neighbouring fields, and one that ignored the mask polarity would leave fields frozen. It probes the hole at 0x2C, unaligned offsets and offsets past the status words. A decoder that aliased them would write a real control word or miss the error response. It issues setup-only phases and writes to the status words; a design that wrote early or let status offsets fall through to storage would change the outputs. Status reads are checked one cycle after the inputs move, so a capture stage that is missing or doubled shows up as a mismatch.

// File: rtl/wm_csr_pkg.sv
package wm_csr_pkg;
  localparam int unsigned BUS_W     = 32;
  localparam int unsigned HALF_W    = BUS_W / 2;
  localparam int unsigned NUM_CTL   = 11;
  localparam int unsigned NUM_STAT  = 2;
  localparam int unsigned STAT_BASE = 12; // word index of offset 0x30

  // control word indices (byte offset = 4 * index)
  localparam int unsigned IDX_PWR   = 0;
  localparam int unsigned IDX_DIV   = 1;
  localparam int unsigned IDX_CLK   = 2;
  localparam int unsigned IDX_EMPH  = 3;
  localparam int unsigned IDX_AMP   = 4;
  localparam int unsigned IDX_DRV   = 5;
  localparam int unsigned IDX_SSC   = 6;
  localparam int unsigned IDX_SPARE = 7;
  localparam int unsigned IDX_PLLH  = 8;
  localparam int unsigned IDX_TXC   = 9;
  localparam int unsigned IDX_AUX   = 10;

  // lanes idle and powered down, PLL off
  function automatic logic [HALF_W-1:0] ctl_reset(input int unsigned idx);
    return (idx == IDX_PWR) ? HALF_W'(16'h0FF1) : '0;
  endfunction
endpackage

// File: rtl/wm_csr_decode.sv
module wm_csr_decode #(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned NUM_CTL   = 11,
  parameter int unsigned NUM_STAT  = 2,
  parameter int unsigned STAT_BASE = 12
) (
  input  logic [ADDR_W-1:0]   addr,
  output logic [NUM_CTL-1:0]  ctl_sel,
  output logic [NUM_STAT-1:0] stat_sel,
  output logic                hit
);
  localparam int unsigned IDX_W = ADDR_W - 2;

  logic             aligned;
  logic [IDX_W-1:0] word;

  assign aligned = (addr[1:0] == 2'b00);
  assign word    = addr[ADDR_W-1:2];

  for (genvar i = 0; i < NUM_CTL; i++) begin : g_ctl
    assign ctl_sel[i] = aligned && (word == IDX_W'(i));
  end

  for (genvar j = 0; j < NUM_STAT; j++) begin : g_stat
    assign stat_sel[j] = aligned && (word == IDX_W'(STAT_BASE + j));
  end

  assign hit = |{ctl_sel, stat_sel};
endmodule

// File: rtl/wm_csr_reg.sv
module wm_csr_reg #(
  parameter int unsigned  W   = 16,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] wmask,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= RST;
    end else if (we) begin
      q <= (q & ~wmask) | (wdata & wmask);
    end
  end
endmodule

// File: rtl/wm_csr_status.sv
module wm_csr_status #(
  parameter int unsigned W = 16,
  parameter int unsigned N = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N*W-1:0] d,
  output logic [N*W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else begin
      q <= d;
    end
  end
endmodule

// File: rtl/wmask_csr_bank.sv
module wmask_csr_bank #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned LANES  = 4
) (
  input  logic                 pclk,
  input  logic                 presetn,
  input  logic                 psel,
  input  logic                 penable,
  input  logic                 pwrite,
  input  logic [ADDR_W-1:0]    paddr,
  input  logic [31:0]          pwdata,
  output logic [31:0]          prdata,
  output logic                 pready,
  output logic                 pslverr,
  input  logic                 pll_ready,
  input  logic [15:0]          phy_status,
  output logic [LANES-1:0]     lane_idle,
  output logic [LANES-1:0]     lane_pd,
  output logic                 iddq_en,
  output logic                 pll_pd,
  output logic [14:0]          pll_fbdiv,
  output logic [2:0]           term_sel,
  output logic [1:0]           rate_sel,
  output logic [3:0]           ref_div,
  output logic [4*LANES-1:0]   emph,
  output logic [3*LANES-1:0]   amp,
  output logic [2*LANES-1:0]   amp_scale,
  output logic [1:0]           tx_mode,
  output logic [3:0]           ssc_depth,
  output logic                 ssc_en,
  output logic [9:0]           ssc_count,
  output logic [15:0]          spare_ctl,
  output logic [15:0]          pll_ctl_hi,
  output logic [15:0]          tx_ctl,
  output logic                 aux_rx_pd_sel,
  output logic                 aux_tx_pd_sel,
  output logic                 aux_idle,
  output logic                 aux_rx_pd,
  output logic                 aux_tx_pd
);
  import wm_csr_pkg::*;

  localparam int unsigned HW = HALF_W;
  localparam int unsigned NC = NUM_CTL;
  localparam int unsigned NS = NUM_STAT;

  logic          access, wr_acc, rd_acc;
  logic [NC-1:0] ctl_sel;
  logic [NS-1:0] stat_sel;
  logic          hit;
  logic [HW-1:0] wmask, wdata;
  logic [HW-1:0] ctl_q [NC];
  logic [NS*HW-1:0] stat_d, stat_q;
  logic [HW-1:0] rd_half;

  assign access = psel && penable;
  assign wr_acc = access && pwrite;
  assign rd_acc = access && !pwrite;
  assign wmask  = pwdata[HW +: HW];
  assign wdata  = pwdata[0 +: HW];

  wm_csr_decode #(
    .ADDR_W   (ADDR_W),
    .NUM_CTL  (NC),
    .NUM_STAT (NS),
    .STAT_BASE(STAT_BASE)
  ) u_decode (
    .addr    (paddr),
    .ctl_sel (ctl_sel),
    .stat_sel(stat_sel),
    .hit     (hit)
  );

  for (genvar i = 0; i < NC; i++) begin : g_reg
    wm_csr_reg #(
      .W  (HW),
      .RST(ctl_reset(i))
    ) u_reg (
      .clk  (pclk),
      .rst_n(presetn),
      .we   (wr_acc && ctl_sel[i]),
      .wdata(wdata),
      .wmask(wmask),
      .q    (ctl_q[i])
    );
  end

  assign stat_d = {phy_status, {(HW-1){1'b0}}, pll_ready};

  wm_csr_status #(
    .W(HW),
    .N(NS)
  ) u_status (
    .clk  (pclk),
    .rst_n(presetn),
    .d    (stat_d),
    .q    (stat_q)
  );

  always_comb begin
    rd_half = '0;
    for (int i = 0; i < NC; i++) begin
      if (ctl_sel[i]) rd_half = rd_half | ctl_q[i];
    end
    for (int j = 0; j < NS; j++) begin
      if (stat_sel[j]) rd_half = rd_half | stat_q[j*HW +: HW];
    end
  end

  assign prdata  = rd_acc ? {{HW{1'b0}}, rd_half} : '0;
  assign pslverr = access && !hit;
  assign pready  = 1'b1;

  // power and lane word
  assign lane_idle = ctl_q[IDX_PWR][8 +: LANES];
  assign lane_pd   = ctl_q[IDX_PWR][4 +: LANES];
  assign iddq_en   = ctl_q[IDX_PWR][1];
  assign pll_pd    = ctl_q[IDX_PWR][0];

  // dividers and rate
  assign pll_fbdiv = ctl_q[IDX_DIV][14:0];
  assign term_sel  = ctl_q[IDX_CLK][10:8];
  assign rate_sel  = ctl_q[IDX_CLK][5:4];
  assign ref_div   = ctl_q[IDX_CLK][3:0];

  // per-lane drive settings
  assign emph      = ctl_q[IDX_EMPH][0 +: 4*LANES];
  assign amp_scale = ctl_q[IDX_DRV][0 +: 2*LANES];
  assign tx_mode   = ctl_q[IDX_DRV][9:8];
  for (genvar k = 0; k < LANES; k++) begin : g_amp
    assign amp[3*k +: 3] = ctl_q[IDX_AMP][4*k +: 3];
  end

  // spread spectrum
  assign ssc_depth = ctl_q[IDX_SSC][15:12];
  assign ssc_en    = ctl_q[IDX_SSC][11];
  assign ssc_count = ctl_q[IDX_SSC][9:0];

  // whole-word controls
  assign spare_ctl  = ctl_q[IDX_SPARE];
  assign pll_ctl_hi = ctl_q[IDX_PLLH];
  assign tx_ctl     = ctl_q[IDX_TXC];

  // side channel
  assign aux_rx_pd_sel = ctl_q[IDX_AUX][5];
  assign aux_tx_pd_sel = ctl_q[IDX_AUX][4];
  assign aux_idle      = ctl_q[IDX_AUX][2];
  assign aux_rx_pd     = ctl_q[IDX_AUX][1];
  assign aux_tx_pd     = ctl_q[IDX_AUX][0];
endmodule

// File: rtl/wm_csr_checks.sv
module wm_csr_checks (
  input logic        pclk,
  input logic        presetn,
  input logic        psel,
  input logic        penable,
  input logic        pwrite,
  input logic [7:0]  paddr,
  input logic [31:0] pwdata,
  input logic [31:0] prdata,
  input logic        pslverr,
  input logic        pll_ready,
  input logic [3:0]  lane_idle,
  input logic [3:0]  lane_pd,
  input logic        iddq_en,
  input logic        pll_pd,
  input logic [14:0] pll_fbdiv,
  input logic        ssc_en
);
  logic acc, wr, rd;
  assign acc = psel && penable;
  assign wr  = acc && pwrite;
  assign rd  = acc && !pwrite;

  AST_RESET_IDLE: assert property (@(posedge pclk) disable iff (!presetn)
    $rose(presetn) |-> (lane_idle == 4'hF) && (lane_pd == 4'hF) && pll_pd && !iddq_en); // R1

  AST_MASKED_MERGE: assert property (@(posedge pclk) disable iff (!presetn)
    (wr && paddr == 8'h00) |=> lane_idle ==
      (($past(pwdata[27:24]) & $past(pwdata[11:8])) | (~$past(pwdata[27:24]) & $past(lane_idle)))); // R2

  AST_NO_ACCESS_HOLD: assert property (@(posedge pclk) disable iff (!presetn)
    !wr |=> $stable(pll_fbdiv) && $stable(lane_pd) && $stable(ssc_en)); // R3

  AST_UPPER_ZERO: assert property (@(posedge pclk) disable iff (!presetn)
    rd |-> prdata[31:16] == 16'h0000); // R4

  AST_LOCK_SAMPLE: assert property (@(posedge pclk) disable iff (!presetn)
    ($past(presetn) && rd && paddr == 8'h30) |-> prdata == {31'b0, $past(pll_ready)}); // R8

  AST_STATUS_RO: assert property (@(posedge pclk) disable iff (!presetn)
    (wr && (paddr == 8'h30 || paddr == 8'h34)) |=> $stable(lane_idle) && $stable(pll_fbdiv) && !$past(pslverr)); // R9

  AST_HOLE_ERR: assert property (@(posedge pclk) disable iff (!presetn)
    (acc && paddr == 8'h2C) |-> pslverr && prdata == 32'h0); // R10

  AST_IDLE_QUIET: assert property (@(posedge pclk) disable iff (!presetn)
    !acc |-> !pslverr && prdata == 32'h0); // R11
endmodule

bind wmask_csr_bank wm_csr_checks u_checks (
  .pclk     (pclk),
  .presetn  (presetn),
  .psel     (psel),
  .penable  (penable),
  .pwrite   (pwrite),
  .paddr    (paddr),
  .pwdata   (pwdata),
  .prdata   (prdata),
  .pslverr  (pslverr),
  .pll_ready(pll_ready),
  .lane_idle(lane_idle),
  .lane_pd  (lane_pd),
  .iddq_en  (iddq_en),
  .pll_pd   (pll_pd),
  .pll_fbdiv(pll_fbdiv),
  .ssc_en   (ssc_en)
);

// File: tb/test_wmask_csr_bank.sv
module test_wmask_csr_bank;
  logic        pclk = 1'b0;
  logic        presetn = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [7:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready, pslverr;
  logic        pll_ready = 1'b0;
  logic [15:0] phy_status = '0;
  logic [3:0]  lane_idle, lane_pd;
  logic        iddq_en, pll_pd;
  logic [14:0] pll_fbdiv;
  logic [2:0]  term_sel;
  logic [1:0]  rate_sel;
  logic [3:0]  ref_div;
  logic [15:0] emph;
  logic [11:0] amp;
  logic [7:0]  amp_scale;
  logic [1:0]  tx_mode;
  logic [3:0]  ssc_depth;
  logic        ssc_en;
  logic [9:0]  ssc_count;
  logic [15:0] spare_ctl, pll_ctl_hi, tx_ctl;
  logic        aux_rx_pd_sel, aux_tx_pd_sel, aux_idle, aux_rx_pd, aux_tx_pd;

  always #10 pclk = ~pclk; // 50 MHz

  wmask_csr_bank i_wmask_csr_bank (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready), .pslverr(pslverr),
    .pll_ready(pll_ready), .phy_status(phy_status),
    .lane_idle(lane_idle), .lane_pd(lane_pd), .iddq_en(iddq_en), .pll_pd(pll_pd),
    .pll_fbdiv(pll_fbdiv), .term_sel(term_sel), .rate_sel(rate_sel), .ref_div(ref_div),
    .emph(emph), .amp(amp), .amp_scale(amp_scale), .tx_mode(tx_mode),
    .ssc_depth(ssc_depth), .ssc_en(ssc_en), .ssc_count(ssc_count),
    .spare_ctl(spare_ctl), .pll_ctl_hi(pll_ctl_hi), .tx_ctl(tx_ctl),
    .aux_rx_pd_sel(aux_rx_pd_sel), .aux_tx_pd_sel(aux_tx_pd_sel), .aux_idle(aux_idle),
    .aux_rx_pd(aux_rx_pd), .aux_tx_pd(aux_tx_pd)
  );

  int checks = 0;
  int errors = 0;
  bit mon_on = 1'b0;

  // behavioural reference state
  logic [15:0] m_ctl [11];
  logic        m_pll;
  logic [15:0] m_stat;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic bit is_ctl(input logic [7:0] a);
    return (a[1:0] == 2'b00) && (a <= 8'h28);
  endfunction

  function automatic bit is_dec(input logic [7:0] a);
    return is_ctl(a) || a == 8'h30 || a == 8'h34;
  endfunction

  function automatic logic [31:0] exp_rd(input logic [7:0] a);
    if (is_ctl(a)) return {16'h0, m_ctl[a >> 2]};
    if (a == 8'h30) return {31'h0, m_pll};
    if (a == 8'h34) return {16'h0, m_stat};
    return 32'h0;
  endfunction

  always @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      for (int i = 0; i < 11; i++) m_ctl[i] = 16'h0000;
      m_ctl[0] = 16'h0FF1;
      m_pll    = 1'b0;
      m_stat   = 16'h0000;
    end else begin
      if (psel && penable && pwrite && is_ctl(paddr)) begin
        int idx;
        idx = int'(paddr >> 2);
        m_ctl[idx] = (m_ctl[idx] & ~pwdata[31:16]) | (pwdata[15:0] & pwdata[31:16]);
      end
      m_pll  = pll_ready;
      m_stat = phy_status;
    end
  end

  // every-cycle comparison against the reference, away from the active edge
  always @(negedge pclk) begin
    if (mon_on) begin
      chk("R5", "lane_idle", 32'(lane_idle), 32'(m_ctl[0][11:8]));
      chk("R5", "lane_pd",   32'(lane_pd),   32'(m_ctl[0][7:4]));
      chk("R5", "iddq_en",   32'(iddq_en),   32'(m_ctl[0][1]));
      chk("R5", "pll_pd",    32'(pll_pd),    32'(m_ctl[0][0]));
      chk("R6", "pll_fbdiv", 32'(pll_fbdiv), 32'(m_ctl[1][14:0]));
      chk("R6", "term_sel",  32'(term_sel),  32'(m_ctl[2][10:8]));
      chk("R6", "rate_sel",  32'(rate_sel),  32'(m_ctl[2][5:4]));
      chk("R6", "ref_div",   32'(ref_div),   32'(m_ctl[2][3:0]));
      chk("R7", "emph",      32'(emph),      32'(m_ctl[3]));
      chk("R7", "amp",       32'(amp), 32'({m_ctl[4][14:12], m_ctl[4][10:8], m_ctl[4][6:4], m_ctl[4][2:0]}));
      chk("R7", "amp_scale", 32'(amp_scale), 32'(m_ctl[5][7:0]));
      chk("R7", "tx_mode",   32'(tx_mode),   32'(m_ctl[5][9:8]));
      chk("R7", "ssc_depth", 32'(ssc_depth), 32'(m_ctl[6][15:12]));
      chk("R7", "ssc_en",    32'(ssc_en),    32'(m_ctl[6][11]));
      chk("R7", "ssc_count", 32'(ssc_count), 32'(m_ctl[6][9:0]));
      chk("R7", "spare_ctl", 32'(spare_ctl), 32'(m_ctl[7]));
      chk("R7", "pll_ctl_hi", 32'(pll_ctl_hi), 32'(m_ctl[8]));
      chk("R7", "tx_ctl",    32'(tx_ctl),    32'(m_ctl[9]));
      chk("R7", "aux bits",  32'({aux_rx_pd_sel, aux_tx_pd_sel, aux_idle, aux_rx_pd, aux_tx_pd}),
          32'({m_ctl[10][5], m_ctl[10][4], m_ctl[10][2], m_ctl[10][1], m_ctl[10][0]}));
      chk("R11", "pready", 32'(pready), 32'h1);
      chk("R4", "prdata", prdata, (psel && penable && !pwrite) ? exp_rd(paddr) : 32'h0);
      chk("R10", "pslverr", 32'(pslverr), 32'(psel && penable && !is_dec(paddr)));
    end
  end

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d, output logic err);
    @(posedge pclk); #2;
    psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
    @(posedge pclk); #2;
    penable = 1'b1;
    @(negedge pclk);
    err = pslverr;
    @(posedge pclk); #2;
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d, output logic err);
    @(posedge pclk); #2;
    psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
    @(posedge pclk); #2;
    penable = 1'b1;
    @(negedge pclk);
    d = prdata;
    err = pslverr;
    @(posedge pclk); #2;
    psel = 1'b0; penable = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge pclk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic        er;
    logic [15:0] vals [11];
    repeat (3) @(posedge pclk);
    #2 presetn = 1'b1;
    @(posedge pclk); #2;
    mon_on = 1'b1;

    // R1: reset state
    chk("R1", "lane_idle after reset", 32'(lane_idle), 32'hF);
    chk("R1", "pll_pd after reset", 32'(pll_pd), 32'h1);
    bus_read(8'h00, rd, er);
    chk("R1", "read 0x00", rd, 32'h0000_0FF1);
    bus_read(8'h18, rd, er);
    chk("R1", "read 0x18", rd, 32'h0);

    // R2: masked writes
    bus_write(8'h00, 32'h0F00_0300, er);
    bus_read(8'h00, rd, er);
    chk("R2", "idle field only", rd, 32'h0000_03F1);
    bus_write(8'h08, 32'h0000_FFFF, er);
    bus_read(8'h08, rd, er);
    chk("R2", "zero mask", rd, 32'h0);
    bus_write(8'h04, 32'hFFFF_1234, er);
    @(negedge pclk);
    chk("R2", "pll_fbdiv full mask", 32'(pll_fbdiv), 32'h1234);

    // R3: setup phase without access phase
    @(posedge pclk); #2;
    psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = 8'h08; pwdata = 32'hFFFF_FFFF;
    @(posedge pclk); #2;
    psel = 1'b0; pwrite = 1'b0;
    bus_read(8'h08, rd, er);
    chk("R3", "setup only leaves word", rd, 32'h0);

    // R5 / R6: field positions
    bus_write(8'h00, 32'hFFFF_0A52, er);
    @(negedge pclk);
    chk("R5", "lane_idle", 32'(lane_idle), 32'hA);
    chk("R5", "lane_pd", 32'(lane_pd), 32'h5);
    chk("R5", "iddq_en", 32'(iddq_en), 32'h1);
    bus_write(8'h08, 32'hFFFF_0512, er);
    @(negedge pclk);
    chk("R6", "term/rate/ref", 32'({term_sel, rate_sel, ref_div}), 32'({3'd5, 2'd1, 4'd2}));

    // R7: spread and amplitude
    bus_write(8'h18, 32'hFFFF_AB7D, er);
    @(negedge pclk);
    chk("R7", "ssc fields", 32'({ssc_depth, ssc_en, ssc_count}), 32'({4'hA, 1'b1, 10'h37D}));
    bus_write(8'h10, 32'hFFFF_7531, er);
    @(negedge pclk);
    chk("R7", "amp packing", 32'(amp), 32'h0000_0F59);

    // R4: every control word independent
    for (int i = 0; i < 11; i++) begin
      vals[i] = 16'hA5A5 ^ 16'(i * 16'h0123);
      bus_write(8'(4 * i), {16'hFFFF, vals[i]}, er);
    end
    for (int i = 0; i < 11; i++) begin
      bus_read(8'(4 * i), rd, er);
      chk("R4", "readback word", rd, {16'h0, vals[i]});
      chk("R4", "no error on word", 32'(er), 32'h0);
    end

    // R8: status capture
    pll_ready = 1'b1; phy_status = 16'hBEEF;
    bus_read(8'h30, rd, er);
    chk("R8", "lock bit", rd, 32'h1);
    bus_read(8'h34, rd, er);
    chk("R8", "status word", rd, 32'h0000_BEEF);
    pll_ready = 1'b0;
    bus_read(8'h30, rd, er);
    chk("R8", "lock drop", rd, 32'h0);

    // R9: status words ignore writes
    bus_write(8'h30, 32'hFFFF_FFFF, er);
    chk("R9", "no error on status write", 32'(er), 32'h0);
    bus_write(8'h34, 32'hFFFF_0000, er);
    bus_read(8'h30, rd, er);
    chk("R9", "lock unaffected", rd, 32'h0);
    bus_read(8'h00, rd, er);
    chk("R9", "word 0 unaffected", rd, {16'h0, vals[0]});

    // R10: undecoded offsets
    bus_write(8'h2C, 32'hFFFF_FFFF, er);
    chk("R10", "hole write error", 32'(er), 32'h1);
    bus_read(8'h2C, rd, er);
    chk("R10", "hole read data", rd, 32'h0);
    chk("R10", "hole read error", 32'(er), 32'h1);
    bus_read(8'h05, rd, er);
    chk("R10", "unaligned error", 32'(er), 32'h1);
    bus_write(8'h29, 32'hFFFF_0000, er);
    bus_read(8'h28, rd, er);
    chk("R10", "unaligned write ignored", rd, {16'h0, vals[10]});
    bus_read(8'h38, rd, er);
    chk("R10", "past status error", 32'(er), 32'h1);
    bus_read(8'hFC, rd, er);
    chk("R10", "top offset data", rd, 32'h0);

    // R11: idle bus
    @(negedge pclk);
    chk("R11", "idle pslverr", 32'(pslverr), 32'h0);
    chk("R11", "idle prdata", prdata, 32'h0);

    repeat (2) @(posedge pclk);
    mon_on = 1'b0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule